// File: doc/BRIEF.md
# Serial Flash Command Engine

This block issues one serial flash command per software request over a single-lane SPI link at single transfer rate. Software programs a command word that holds the opcode, the number of address bytes, the data direction and the data byte count. It also programs an address word and up to two words of outgoing data. It then sets the start bit. The engine drives chip select low and shifts out the opcode, the address bytes and the data phase. It then releases chip select, holds it high for a short gap, and raises a sticky completion flag.

Because every part of the frame comes from the command word, one engine can run a write-enable (no address, no data), an erase (opcode plus address), a register or array read (address plus incoming bytes), or a program command (address plus outgoing bytes). The engine never adds a command on its own. An erase or program must be preceded by a separate write-enable command, and software issues it. The register port is a plain single-cycle write strobe with a combinational read. Data moves only through registers, so there is no streaming interface and no back-pressure.

Register word addresses: 0 command word, 1 address, 2 control/status, 3 and 4 outgoing data (low word first), 5 and 6 incoming data (low word first). Control bits: bit 0 start (write 1), bit 1 busy (read only), bit 2 done (read, write 1 to clear).

Top module: `flash_cmd_engine`

## Requirements
- R1: Command word bits [7:0] are the opcode. It is always the first byte on the data-out line, most significant bit first, and the frame continues with the address bytes and then the data phase.
- R2: Command word bits [10:8] give the address byte count n. A value of 0 sends no address. Values 1 to 4 send the low n bytes of the address register, most significant byte first. Values above 4 are treated as 4.
- R3: Command word bits [15:12] give the data byte count. A value of 0 means no data phase, and values above 8 are treated as 8. When bit 11 is 0, the bytes are sent from the outgoing data words: byte 0 first, taken from bits [7:0] of word 3, each byte most significant bit first. When bit 11 is 1, the data-out line is held at 0 for the whole data phase.
- R4: When bit 11 is 1, each data byte is assembled from the data-in line, most significant bit first. Received byte k lands in bits [8k+7:8k] of the 64-bit value formed by word 6 (high) and word 5 (low). Bytes beyond the count read as 0, because the incoming words are cleared when a command starts.
- R5: SPI mode 0 is used. The serial clock idles low and runs at half the system clock. Data out changes only when the serial clock falls (or together with chip select falling), and data in is taken at the rising edge. For a frame of N bits, chip select stays low for exactly 2N+1 system clock cycles, and the serial clock has exactly N rising edges.
- R6: After chip select rises, busy stays high for GAP_CYCLES more cycles. When busy falls, chip select is high and the serial clock is low.
- R7: Writing 1 to control bit 0 while idle starts the command. Chip select falls on the same clock edge that accepts the write, and busy reads 1 from then on.
- R8: A start write while busy is ignored. The running frame keeps its bit count, and no second frame follows.
- R9: Done is set on the edge where busy falls and stays set until software writes 1 to control bit 2. Writing 0 there leaves it set. If a set and a clear fall in the same cycle, the set wins.
- R10: After reset, chip select is high, the serial clock and data out are low, busy and done are 0, and every readable register reads 0.
- R11: The command word, address and outgoing data are captured at start. Register writes during a command change the register contents but not the frame in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register word address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data of the addressed register |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Chip select falls on the clock edge that accepts the start write, so the bench checks it and busy at the first falling system clock edge after that write. For a frame of N bits, chip select stays low for 2N+1 cycles. Busy holds for GAP_CYCLES more cycles, and done and the incoming data words become valid on the edge where busy falls. The bench counts falling system clock edges against these exact figures and never polls with slack. A flash responder in the bench records data out at each serial clock rise and presents data in from a random bit stream. All inputs change and all outputs are read at falling system clock edges, half a cycle away from the edges where the design updates.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  // Command word layout; field positions are fixed by the register contract.
  typedef struct packed {
    logic [3:0] data_cnt;  // [15:12]
    logic       data_rd;   // [11]
    logic [2:0] addr_cnt;  // [10:8]
    logic [7:0] opcode;    // [7:0]
  } cmd_word_t;

  localparam int CMD_W = $bits(cmd_word_t);

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_RUN,
    SQ_TAIL,
    SQ_GAP
  } seq_state_e;

  // Control register bit positions.
  localparam int CTL_GO   = 0;
  localparam int CTL_BUSY = 1;
  localparam int CTL_DONE = 2;

  // Fixed register word addresses; data words follow.
  localparam int RW_CMD  = 0;
  localparam int RW_ADDR = 1;
  localparam int RW_CTL  = 2;
  localparam int RW_DATA = 3;

endpackage

// File: rtl/flash_cmd_frame.sv
module flash_cmd_frame
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_BYTES = 8,
  parameter int CNT_W     = 7
) (
  input  cmd_word_t                      cmd_i,
  input  logic [DATA_W-1:0]              addr_i,
  input  logic [8*BUF_BYTES-1:0]         wbuf_i,
  input  logic [CNT_W-1:0]               bit_idx_i,
  output logic                           tx_bit_o,
  output logic                           rd_en_o,
  output logic [$clog2(8*BUF_BYTES)-1:0] rd_pos_o,
  output logic [CNT_W-1:0]               total_bits_o
);

  localparam int ADDR_BYTES = DATA_W / 8;
  localparam int AIDX_W     = $clog2(DATA_W);
  localparam int BIDX_W     = $clog2(8 * BUF_BYTES);
  localparam int DCNT_MAX   = (BUF_BYTES > 15) ? 15 : BUF_BYTES;

  // Decode which byte and bit of the frame the bit index points at.
  always_comb begin
    int na;
    int nd;
    int byte_n;
    int bpos;
    int ab;
    int db;
    na     = (int'(cmd_i.addr_cnt) > ADDR_BYTES) ? ADDR_BYTES : int'(cmd_i.addr_cnt);
    nd     = (int'(cmd_i.data_cnt) > DCNT_MAX) ? DCNT_MAX : int'(cmd_i.data_cnt);
    byte_n = int'(bit_idx_i) / 8;
    bpos   = 7 - (int'(bit_idx_i) % 8);
    ab     = 0;
    db     = 0;
    tx_bit_o     = 1'b0;
    rd_en_o      = 1'b0;
    rd_pos_o     = '0;
    total_bits_o = CNT_W'(8 * (1 + na + nd));
    if (byte_n == 0) begin
      tx_bit_o = cmd_i.opcode[3'(bpos)];
    end else if (byte_n <= na) begin
      ab       = na - byte_n;
      tx_bit_o = addr_i[AIDX_W'(ab * 8 + bpos)];
    end else begin
      db = byte_n - 1 - na;
      if (db < nd) begin
        if (cmd_i.data_rd) begin
          rd_en_o  = 1'b1;
          rd_pos_o = BIDX_W'(db * 8 + bpos);
        end else begin
          tx_bit_o = wbuf_i[BIDX_W'(db * 8 + bpos)];
        end
      end
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BUF_BYTES  = 8,
  parameter int CNT_W      = 7,
  parameter int GAP_CYCLES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           go_i,
  input  cmd_word_t                      cmd_i,
  input  logic [DATA_W-1:0]              addr_i,
  input  logic [8*BUF_BYTES-1:0]         wbuf_i,
  input  logic                           tx_bit_i,
  input  logic                           rd_en_i,
  input  logic [$clog2(8*BUF_BYTES)-1:0] rd_pos_i,
  input  logic [CNT_W-1:0]               total_bits_i,
  input  logic                           miso_i,
  output cmd_word_t                      snap_cmd_o,
  output logic [DATA_W-1:0]              snap_addr_o,
  output logic [8*BUF_BYTES-1:0]         snap_wbuf_o,
  output logic [CNT_W-1:0]               bit_idx_o,
  output logic [8*BUF_BYTES-1:0]         rbuf_o,
  output logic                           busy_o,
  output logic                           finish_o,
  output logic                           sclk_o,
  output logic                           cs_n_o,
  output logic                           mosi_o
);

  localparam int GAP_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

  seq_state_e             state_q;
  logic                   ph_q;
  logic                   last_q;
  logic [CNT_W-1:0]       bit_idx_q;
  logic [GAP_W-1:0]       gap_q;
  cmd_word_t              snap_cmd_q;
  logic [DATA_W-1:0]      snap_addr_q;
  logic [8*BUF_BYTES-1:0] snap_wbuf_q;
  logic [8*BUF_BYTES-1:0] rbuf_q;
  logic                   sclk_q;
  logic                   cs_n_q;
  logic                   mosi_q;

  assign finish_o = (state_q == SQ_GAP) && (gap_q == GAP_W'(GAP_CYCLES - 1));
  assign busy_o   = (state_q != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      ph_q        <= 1'b0;
      last_q      <= 1'b0;
      bit_idx_q   <= '0;
      gap_q       <= '0;
      snap_cmd_q  <= '0;
      snap_addr_q <= '0;
      snap_wbuf_q <= '0;
      rbuf_q      <= '0;
      sclk_q      <= 1'b0;
      cs_n_q      <= 1'b1;
      mosi_q      <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (go_i) begin
            snap_cmd_q  <= cmd_i;
            snap_addr_q <= addr_i;
            snap_wbuf_q <= wbuf_i;
            rbuf_q      <= '0;
            cs_n_q      <= 1'b0;
            sclk_q      <= 1'b0;
            mosi_q      <= cmd_i.opcode[7];
            ph_q        <= 1'b0;
            last_q      <= 1'b0;
            bit_idx_q   <= '0;
            state_q     <= SQ_RUN;
          end
        end
        SQ_RUN: begin
          if (!ph_q) begin
            // Rising serial clock: take data in, step to the next bit.
            sclk_q <= 1'b1;
            ph_q   <= 1'b1;
            if (rd_en_i) rbuf_q[rd_pos_i] <= miso_i;
            if (bit_idx_q == total_bits_i - 1'b1) last_q <= 1'b1;
            else bit_idx_q <= bit_idx_q + 1'b1;
          end else begin
            // Falling serial clock: present the next bit or wind up.
            sclk_q <= 1'b0;
            ph_q   <= 1'b0;
            if (last_q) begin
              mosi_q  <= 1'b0;
              state_q <= SQ_TAIL;
            end else begin
              mosi_q <= tx_bit_i;
            end
          end
        end
        SQ_TAIL: begin
          cs_n_q  <= 1'b1;
          gap_q   <= '0;
          state_q <= SQ_GAP;
        end
        SQ_GAP: begin
          if (finish_o) state_q <= SQ_IDLE;
          else gap_q <= gap_q + 1'b1;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign snap_cmd_o  = snap_cmd_q;
  assign snap_addr_o = snap_addr_q;
  assign snap_wbuf_o = snap_wbuf_q;
  assign bit_idx_o   = bit_idx_q;
  assign rbuf_o      = rbuf_q;
  assign sclk_o      = sclk_q;
  assign cs_n_o      = cs_n_q;
  assign mosi_o      = mosi_q;

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sclk_q); // R5

  AST_SCLK_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_RUN && $past(state_q == SQ_RUN)) |-> (sclk_q != $past(sclk_q))); // R5

  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_q && $past(!cs_n_q) && !$stable(mosi_q)) |-> $fell(sclk_q)); // R5

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE) |-> (cs_n_q && !sclk_q)); // R6

  AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SQ_IDLE) |=> ($stable(snap_cmd_q) && $stable(snap_addr_q))); // R11

endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int WD_WORDS = 2,
  parameter int ADDR_W   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr_i,
  input  logic [ADDR_W-1:0]            reg_addr_i,
  input  logic [DATA_W-1:0]            reg_wdata_i,
  output logic [DATA_W-1:0]            reg_rdata_o,
  input  logic                         busy_i,
  input  logic                         finish_i,
  input  logic [WD_WORDS*DATA_W-1:0]   rbuf_i,
  output logic                         go_o,
  output cmd_word_t                    cmd_o,
  output logic [DATA_W-1:0]            addr_o,
  output logic [WD_WORDS*DATA_W-1:0]   wbuf_o
);

  localparam int RD_BASE = RW_DATA + WD_WORDS;

  cmd_word_t         cmd_q;
  logic [DATA_W-1:0] addr_q;
  logic              done_q;
  logic [DATA_W-1:0] wd_q [WD_WORDS];
  logic              ctl_wr;
  logic              done_clr;

  assign ctl_wr   = reg_wr_i && (reg_addr_i == ADDR_W'(RW_CTL));
  assign done_clr = ctl_wr && reg_wdata_i[CTL_DONE];
  assign go_o     = ctl_wr && reg_wdata_i[CTL_GO] && !busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (reg_wr_i && reg_addr_i == ADDR_W'(RW_CMD)) cmd_q <= cmd_word_t'(reg_wdata_i[CMD_W-1:0]);
      if (reg_wr_i && reg_addr_i == ADDR_W'(RW_ADDR)) addr_q <= reg_wdata_i;
      if (finish_i) done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
    end
  end

  for (genvar w = 0; w < WD_WORDS; w++) begin : g_wd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wd_q[w] <= '0;
      else if (reg_wr_i && reg_addr_i == ADDR_W'(RW_DATA + w)) wd_q[w] <= reg_wdata_i;
    end
    assign wbuf_o[w*DATA_W +: DATA_W] = wd_q[w];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(RW_CMD)) reg_rdata_o = {{(DATA_W-CMD_W){1'b0}}, cmd_q};
    if (reg_addr_i == ADDR_W'(RW_ADDR)) reg_rdata_o = addr_q;
    if (reg_addr_i == ADDR_W'(RW_CTL)) begin
      reg_rdata_o[CTL_BUSY] = busy_i;
      reg_rdata_o[CTL_DONE] = done_q;
    end
    for (int w = 0; w < WD_WORDS; w++) begin
      if (reg_addr_i == ADDR_W'(RW_DATA + w)) reg_rdata_o = wd_q[w];
      if (reg_addr_i == ADDR_W'(RD_BASE + w)) reg_rdata_o = rbuf_i[w*DATA_W +: DATA_W];
    end
  end

  assign cmd_o  = cmd_q;
  assign addr_o = addr_q;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !done_clr) |=> done_q); // R9

  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !busy_i); // R6

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !finish_i) |=> !done_q); // R9

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int WD_WORDS   = 2,
  parameter int GAP_CYCLES = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   reg_wr,
  input  logic [$clog2(RW_DATA+2*WD_WORDS)-1:0] reg_addr,
  input  logic [DATA_W-1:0]                      reg_wdata,
  output logic [DATA_W-1:0]                      reg_rdata,
  output logic                                   spi_sclk,
  output logic                                   spi_cs_n,
  output logic                                   spi_mosi,
  input  logic                                   spi_miso
);

  localparam int ADDR_W     = $clog2(RW_DATA + 2 * WD_WORDS);
  localparam int BUF_BYTES  = WD_WORDS * DATA_W / 8;
  localparam int ADDR_BYTES = DATA_W / 8;
  localparam int DCNT_MAX   = (BUF_BYTES > 15) ? 15 : BUF_BYTES;
  localparam int MAX_BITS   = 8 * (1 + ADDR_BYTES + DCNT_MAX);
  localparam int CNT_W      = $clog2(MAX_BITS + 1);
  localparam int BIDX_W     = $clog2(8 * BUF_BYTES);

  logic                   go;
  logic                   busy;
  logic                   finish;
  cmd_word_t              cmd;
  cmd_word_t              snap_cmd;
  logic [DATA_W-1:0]      addr;
  logic [DATA_W-1:0]      snap_addr;
  logic [8*BUF_BYTES-1:0] wbuf;
  logic [8*BUF_BYTES-1:0] snap_wbuf;
  logic [8*BUF_BYTES-1:0] rbuf;
  logic [CNT_W-1:0]       bit_idx;
  logic [CNT_W-1:0]       total_bits;
  logic                   tx_bit;
  logic                   rd_en;
  logic [BIDX_W-1:0]      rd_pos;

  flash_cmd_regs #(
    .DATA_W   (DATA_W),
    .WD_WORDS (WD_WORDS),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .busy_i      (busy),
    .finish_i    (finish),
    .rbuf_i      (rbuf),
    .go_o        (go),
    .cmd_o       (cmd),
    .addr_o      (addr),
    .wbuf_o      (wbuf)
  );

  flash_cmd_seq #(
    .DATA_W     (DATA_W),
    .BUF_BYTES  (BUF_BYTES),
    .CNT_W      (CNT_W),
    .GAP_CYCLES (GAP_CYCLES)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_i         (go),
    .cmd_i        (cmd),
    .addr_i       (addr),
    .wbuf_i       (wbuf),
    .tx_bit_i     (tx_bit),
    .rd_en_i      (rd_en),
    .rd_pos_i     (rd_pos),
    .total_bits_i (total_bits),
    .miso_i       (spi_miso),
    .snap_cmd_o   (snap_cmd),
    .snap_addr_o  (snap_addr),
    .snap_wbuf_o  (snap_wbuf),
    .bit_idx_o    (bit_idx),
    .rbuf_o       (rbuf),
    .busy_o       (busy),
    .finish_o     (finish),
    .sclk_o       (spi_sclk),
    .cs_n_o       (spi_cs_n),
    .mosi_o       (spi_mosi)
  );

  flash_cmd_frame #(
    .DATA_W    (DATA_W),
    .BUF_BYTES (BUF_BYTES),
    .CNT_W     (CNT_W)
  ) u_frame (
    .cmd_i        (snap_cmd),
    .addr_i       (snap_addr),
    .wbuf_i       (snap_wbuf),
    .bit_idx_i    (bit_idx),
    .tx_bit_o     (tx_bit),
    .rd_en_o      (rd_en),
    .rd_pos_o     (rd_pos),
    .total_bits_o (total_bits)
  );

endmodule

// File: tb/flash_cmd_engine_test.sv
module flash_cmd_engine_test;

  localparam int GAP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sclk, cs_n, mosi, miso;

  int n_chk = 0;
  int n_fail = 0;

  logic [127:0] stream = '0;
  logic [127:0] rx_bits = '0;
  logic [7:0]   rx_cnt = '0;

  always #4 clk = ~clk;

  flash_cmd_engine #(.DATA_W(32), .WD_WORDS(2), .GAP_CYCLES(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(sclk),
    .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
  );

  // Flash responder: records data out on each rise, serves the stream.
  always @(negedge cs_n or posedge sclk) begin
    if (sclk) begin
      if (!cs_n) begin
        rx_bits[rx_cnt[6:0]] = mosi;
        rx_cnt = rx_cnt + 8'd1;
      end
    end else begin
      rx_bits = '0;
      rx_cnt = '0;
    end
  end
  assign miso = stream[rx_cnt[6:0]];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd2;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic int n_addr(input logic [15:0] s);
    return (s[10:8] > 3'd4) ? 4 : int'(s[10:8]);
  endfunction

  function automatic int n_data(input logic [15:0] s);
    return (s[15:12] > 4'd8) ? 8 : int'(s[15:12]);
  endfunction

  function automatic logic [127:0] exp_frame(input logic [15:0] s, input logic [31:0] a, input logic [63:0] wd);
    logic [127:0] f = '0;
    int p = 0;
    for (int b = 7; b >= 0; b--) begin f[p] = s[b]; p++; end
    for (int i = n_addr(s) - 1; i >= 0; i--)
      for (int b = 7; b >= 0; b--) begin f[p] = a[i*8+b]; p++; end
    for (int j = 0; j < n_data(s); j++)
      for (int b = 7; b >= 0; b--) begin f[p] = s[11] ? 1'b0 : wd[j*8+b]; p++; end
    return f;
  endfunction

  function automatic logic [63:0] exp_read(input logic [15:0] s, input logic [127:0] st);
    logic [63:0] r = '0;
    for (int j = 0; j < n_data(s); j++)
      for (int b = 7; b >= 0; b--) r[j*8+b] = st[(1 + n_addr(s) + j) * 8 + 7 - b];
    return r;
  endfunction

  // inject: 0 none, 1 start write mid-frame, 2 command word write mid-frame
  task automatic run_cmd(input logic [15:0] s, input logic [31:0] a, input logic [63:0] wd, input int inject);
    int nbits, cs_low, tail;
    logic [31:0] r0, r1, c;
    nbits = 8 * (1 + n_addr(s) + n_data(s));
    stream = {$urandom, $urandom, $urandom, $urandom};
    reg_write(3'd0, {16'h0, s});
    reg_write(3'd1, a);
    reg_write(3'd3, wd[31:0]);
    reg_write(3'd4, wd[63:32]);
    reg_write(3'd2, 32'h1);
    #1;
    chk(cs_n == 1'b0, "R7 chip select low after start", cs_n, 0);
    chk(reg_rdata[1] == 1'b1, "R7 busy after start", reg_rdata[1], 1);
    cs_low = 0;
    while (cs_n == 1'b0 && cs_low < 1000) begin
      cs_low++;
      if (inject != 0 && cs_low == 3) begin
        reg_wr = 1'b1;
        reg_addr = (inject == 1) ? 3'd2 : 3'd0;
        reg_wdata = (inject == 1) ? 32'h1 : 32'h0000FFFF;
      end else begin
        reg_wr = 1'b0; reg_addr = 3'd2;
      end
      @(negedge clk);
    end
    #1;
    tail = 0;
    while (reg_rdata[1] && tail < 100) begin
      tail++;
      @(negedge clk);
      #1;
    end
    chk(cs_low == 2 * nbits + 1, "R5 chip select low cycles", cs_low, 2 * nbits + 1);
    chk(int'(rx_cnt) == nbits, "R5 serial clock rises", rx_cnt, nbits);
    chk(rx_bits == exp_frame(s, a, wd),
        (inject == 2) ? "R11 frame after mid-command write" : "R1 R2 R3 frame bits",
        rx_bits, exp_frame(s, a, wd));
    chk(tail == GAP, "R6 busy tail after chip select rise", tail, GAP);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R6 lines released at idle", {cs_n, sclk}, 2'b10);
    chk(reg_rdata[2] == 1'b1, "R9 done set at completion", reg_rdata[2], 1);
    if (s[11] && n_data(s) > 0) begin
      reg_read(3'd5, r0);
      reg_read(3'd6, r1);
      chk({r1, r0} == exp_read(s, stream), "R4 received bytes", {r1, r0}, exp_read(s, stream));
    end
    if (inject == 1) begin
      repeat (6) @(negedge clk);
      chk(cs_n == 1'b1 && int'(rx_cnt) == nbits, "R8 start while busy ignored", rx_cnt, nbits);
    end
    if (inject == 2) begin
      reg_read(3'd0, c);
      chk(c == 32'h0000FFFF, "R11 register write accepted while busy", c, 32'hFFFF);
    end
    reg_write(3'd2, 32'h0);
    reg_read(3'd2, c);
    chk(c[2] == 1'b1 && cs_n == 1'b1, "R9 writing zero keeps done", c[2], 1);
    reg_write(3'd2, 32'h4);
    reg_read(3'd2, c);
    chk(c[2] == 1'b0, "R9 done cleared by write one", c[2], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R7 watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R10 serial lines after reset",
        {cs_n, sclk, mosi}, 3'b100);
    for (int i = 0; i < 7; i++) begin
      reg_read(3'(i), v);
      chk(v == 32'h0, "R10 register reads zero after reset", v, 0);
    end
    // Directed: write enable, sector erase, reads, program, clamped counts.
    run_cmd(16'h0006, 32'h0, 64'h0, 0);
    run_cmd(16'h04D8, 32'h0000_1000, 64'h0, 0);
    run_cmd(16'h8B03, 32'hA5C3_7E01, 64'h0, 0);
    run_cmd(16'h4412, 32'h0102_0304, 64'hDEAD_BEEF_1234_5678, 0);
    run_cmd(16'hF70B, 32'hFFEE_DDCC, 64'h0F1E_2D3C_4B5A_6978, 0);
    run_cmd(16'hFF0B, 32'h1357_9BDF, 64'h0, 0);
    run_cmd(16'h1102, 32'h0000_00AB, 64'h0000_0000_0000_00C6, 0);
    run_cmd(16'h3A9F, 32'h0, 64'h0, 1);
    run_cmd(16'h2302, 32'h0055_AA55, 64'h0000_0000_0000_8181, 2);
    // Random commands.
    for (int n = 0; n < 20; n++) begin
      logic [15:0] s;
      s[7:0]   = 8'($urandom);
      s[10:8]  = 3'($urandom % 6);
      s[11]    = 1'($urandom);
      s[15:12] = 4'($urandom % 11);
      run_cmd(s, $urandom, {$urandom, $urandom}, 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule